// File: doc/BRIEF.md
# Strobed Digital Input Latch

This block is one digital input group that takes a 16-bit word from user input points under the control of an external strobe. The host arms the group with a command. While the group is armed and the host says it can take more data, the group drives a ready line. The user places a word on the input points and then raises the sync line. That rising edge freezes the data register, raises an interrupt request and drops ready. Ready stays low until the host issues a read command.

A rising edge is needed for each capture, so a sync line that stays high never captures a second time. Two test commands replace the real input points with all ones or all zeros and send one pulse into the sync receiver. The group then goes through the same capture and interrupt sequence as it would for a real strobe. The input points and the sync line pass through a two-stage synchronizer. The edge is found on the synchronized sync line, and the data word sampled in that same cycle is the word that gets held.

Top module: `strobe_latch`

## Requirements
- R1: After reset, ready is 0, irq is 0 and rd_data is 0.
- R2: Opcode 1 arms the strobed mode. ready is 1 exactly when the mode is armed, host_accept is 1 and no interrupt is pending. Otherwise ready is 0.
- R3: A 0-to-1 transition on sync_in while ready is 1 captures a word. Three clocks after the transition is applied, irq is 1, ready is 0 and rd_data holds the word that was on the input points when the edge happened. The held word does not change while irq stays 1, whatever the input points do.
- R4: Opcode 2 (read) clears a pending irq. If the mode is still armed and host_accept is 1, ready returns to 1 in the cycle after the command is sampled.
- R5: A sync_in line that stays high after a capture never causes another capture. Only a new 0-to-1 transition can start the next one.
- R6: Opcodes 3 (arm process interrupt), 4 (device reset) and 5 (halt I/O) disarm the mode. In the cycle after the command is sampled, they clear a pending irq and force ready to 0.
- R7: Opcodes 6 and 7 force the input points to all ones or all zeros and send a single pulse into the sync receiver. An armed and ready group then captures the forced word and raises irq three clocks after the command is sampled. While forcing is active, the real input points and the real sync_in have no effect. Opcodes 4 and 5 end the forcing.
- R8: While no interrupt is pending, rd_data follows the input points. A change on the input points shows on rd_data three clocks after it is applied.
- R9: A sync_in edge that arrives while ready is 0, either because the mode is disarmed or because host_accept is 0, sets no irq. It also does not capture later when ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode (see R2, R4, R6, R7) |
| host_accept | input | 1 | Host can accept another word |
| in_points | input | 16 | User input points |
| sync_in | input | 1 | External sync line |
| ready | output | 1 | Group ready for a strobe |
| rd_data | output | 16 | Data register contents |
| irq | output | 1 | Capture interrupt request |

## Verification
A sync rise or an input-point change is applied just after a clock edge. It passes two synchronizer flops and reaches the output registers three edges later. A test command reaches the outputs three edges after the edge that samples it. Read and disarm commands show on ready and irq right after their sampling edge. The bench checks each result one edge before it is due, where the old value must still show, and again in the cycle it is due. All sampling happens 1 ns after an edge, so each check falls on a known cycle and never on the edge itself.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 3'd0,
        OP_ARM_SYNC  = 3'd1,
        OP_READ      = 3'd2,
        OP_ARM_PI    = 3'd3,
        OP_DEV_RST   = 3'd4,
        OP_HALT      = 3'd5,
        OP_TEST_ONE  = 3'd6,
        OP_TEST_ZERO = 3'd7
    } op_e;

    typedef struct packed {
        logic armed;
        logic pend;
        logic test_on;
        logic test_val;
        logic test_pulse;
    } ctl_s;

    function automatic logic op_disarms(op_e op);
        return (op == OP_ARM_PI) || (op == OP_DEV_RST) || (op == OP_HALT);
    endfunction

    function automatic logic op_ends_test(op_e op);
        return (op == OP_DEV_RST) || (op == OP_HALT);
    endfunction

    function automatic logic op_is_test(op_e op);
        return (op == OP_TEST_ONE) || (op == OP_TEST_ZERO);
    endfunction

endpackage

// File: rtl/strobe_rx.sv
module strobe_rx #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic         sync_raw,
    input  logic         test_on,
    input  logic         test_val,
    input  logic         test_pulse,
    output logic [W-1:0] data_s,
    output logic         sync_edge
);
    localparam int LANE = W + 1;
    localparam int LAST = STAGES - 1;

    logic [LANE-1:0] rx_lane;
    logic [LANE-1:0] stage [STAGES];
    logic            sync_d;

    always_comb begin
        rx_lane[W-1:0] = test_on ? {W{test_val}} : pins;
        rx_lane[W]     = test_on ? test_pulse : sync_raw;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= rx_lane;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_d <= 1'b0;
        else     sync_d <= stage[LAST][W];
    end

    assign data_s    = stage[LAST][W-1:0];
    assign sync_edge = stage[LAST][W] & ~sync_d;

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        sync_edge |=> !sync_edge);

endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
    import strobe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            host_accept,
    input  logic            sync_edge,
    output ctl_s            st,
    output logic            ready,
    output logic            capture
);
    op_e op;
    assign op = op_e'(cmd_op);

    assign ready   = st.armed & host_accept & ~st.pend;
    assign capture = sync_edge & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.test_pulse <= 1'b0;
            if (capture) st.pend <= 1'b1;
            if (cmd_valid) begin
                if (op == OP_ARM_SYNC) st.armed <= 1'b1;
                if (op == OP_READ) st.pend <= 1'b0;
                if (op_disarms(op)) begin
                    st.armed <= 1'b0;
                    st.pend  <= 1'b0;
                end
                if (op_ends_test(op)) st.test_on <= 1'b0;
                if (op_is_test(op)) begin
                    st.test_on    <= 1'b1;
                    st.test_val   <= (op == OP_TEST_ONE);
                    st.test_pulse <= 1'b1;
                end
            end
        end
    end

    // R2
    ready_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (st.armed && host_accept));

    // R3
    capture_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && !(cmd_valid && op_disarms(op))) |=> (st.pend && !ready));

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_READ) |=> !st.pend);

    // R6
    disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op_disarms(op)) |=> (!st.armed && !st.pend && !ready));

    // R9
    idle_edge_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_edge && !ready && !cmd_valid) |=> $stable(st.pend));

endmodule

// File: rtl/strobe_hold.sv
module strobe_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst)       data_q <= '0;
        else if (!hold) data_q <= data_in;
    end

    // R3
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(data_q));

endmodule

// File: rtl/strobe_latch.sv
module strobe_latch
    import strobe_pkg::*;
#(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            host_accept,
    input  logic [W-1:0]    in_points,
    input  logic            sync_in,
    output logic            ready,
    output logic [W-1:0]    rd_data,
    output logic            irq
);
    ctl_s         st;
    logic [W-1:0] data_s;
    logic         sync_edge;
    logic         capture;

    strobe_rx #(.W(W), .STAGES(STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .pins      (in_points),
        .sync_raw  (sync_in),
        .test_on   (st.test_on),
        .test_val  (st.test_val),
        .test_pulse(st.test_pulse),
        .data_s    (data_s),
        .sync_edge (sync_edge)
    );

    strobe_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .host_accept(host_accept),
        .sync_edge  (sync_edge),
        .st         (st),
        .ready      (ready),
        .capture    (capture)
    );

    strobe_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .hold   (st.pend),
        .data_in(data_s),
        .data_q (rd_data)
    );

    assign irq = st.pend;

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(capture));

endmodule

// File: tb/strobe_latch_test.sv
module strobe_latch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        host_accept = 1'b0;
    logic [15:0] in_points = 16'h0;
    logic        sync_in = 1'b0;
    logic        ready;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit m_armed = 1'b0;
    bit m_pend = 1'b0;

    always #4 clk = ~clk;

    strobe_latch uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .host_accept(host_accept), .in_points(in_points), .sync_in(sync_in),
        .ready(ready), .rd_data(rd_data), .irq(irq)
    );

    function automatic bit exp_ready(bit armed, bit acc, bit pend);
        return armed && acc && !pend;
    endfunction

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [2:0] op);
        cmd_valid = 1'b1;
        cmd_op = op;
        step();
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        if (op == 3'd1) m_armed = 1'b1;
        if (op == 3'd2) m_pend = 1'b0;
        if (op >= 3'd3 && op <= 3'd5) begin
            m_armed = 1'b0;
            m_pend = 1'b0;
        end
    endtask

    task automatic capture(logic [15:0] word, string req);
        in_points = word;
        sync_in = 1'b0;
        step(3);
        sync_in = 1'b1;
        step(2);
        check({req, " irq not yet"}, irq, 1'b0);
        step();
        m_pend = 1'b1;
        check({req, " irq"}, irq, 1'b1);
        check({req, " ready"}, ready, exp_ready(m_armed, host_accept, m_pend));
        check({req, " word"}, rd_data, word);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        step(3);
        rst = 1'b0;
        step();
        // R1
        check("R1 ready", ready, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 rd_data", rd_data, 16'h0);

        // R8 unarmed tracking, three clocks
        in_points = 16'hA5A5;
        step(2);
        check("R8 before", rd_data, 16'h0);
        step();
        check("R8 follow", rd_data, 16'hA5A5);

        // R9 unarmed edge ignored
        sync_in = 1'b1;
        step(4);
        check("R9 unarmed irq", irq, 1'b0);
        sync_in = 1'b0;
        step(3);

        // R2
        host_accept = 1'b1;
        check("R2 unarmed ready", ready, 1'b0);
        send(3'd1);
        check("R2 armed ready", ready, exp_ready(m_armed, 1'b1, m_pend));
        host_accept = 1'b0;
        #1 check("R2 no accept", ready, 1'b0);
        host_accept = 1'b1;

        // R3 directed
        capture(16'h1234, "R3");
        in_points = 16'hFFFF;
        step(4);
        check("R3 held", rd_data, 16'h1234);

        // R4 and R5: sync stays high
        send(3'd2);
        check("R4 irq cleared", irq, 1'b0);
        check("R4 ready back", ready, 1'b1);
        step(5);
        check("R5 no repeat", irq, 1'b0);
        check("R8 follows after read", rd_data, 16'hFFFF);
        sync_in = 1'b0;
        step(3);

        // random rounds with R9 drops
        for (int r = 0; r < 40; r++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                in_points = w;
                host_accept = 1'b0;
                step(3);
                sync_in = 1'b1;
                step(4);
                check("R9 no accept irq", irq, 1'b0);
                host_accept = 1'b1;
                step(3);
                check("R9 late ready no capture", irq, 1'b0);
                check("R2 ready", ready, exp_ready(m_armed, 1'b1, m_pend));
                sync_in = 1'b0;
                step(3);
            end else begin
                capture(w, "R3 random");
                in_points = ~w;
                step(int'($urandom_range(1, 6)));
                check("R3 random held", rd_data, w);
                send(3'd2);
                check("R4 random", irq, 1'b0);
                check("R4 random ready", ready, exp_ready(m_armed, 1'b1, m_pend));
                sync_in = 1'b0;
            end
        end

        // R6 each disarming opcode
        for (int k = 3; k <= 5; k++) begin
            if (k > 3) send(3'd1);
            capture(16'h0F00 + 16'(k), "R6 setup");
            send(3'(k));
            check("R6 irq", irq, 1'b0);
            check("R6 ready", ready, 1'b0);
            sync_in = 1'b0;
            step(3);
            sync_in = 1'b1;
            step(4);
            check("R6 disarmed edge", irq, 1'b0);
            sync_in = 1'b0;
            step(3);
        end

        // R7 test forcing
        send(3'd1);
        in_points = 16'h0F0F;
        step(3);
        send(3'd6);
        step(2);
        check("R7 ones early", irq, 1'b0);
        step();
        check("R7 ones irq", irq, 1'b1);
        check("R7 ones word", rd_data, 16'hFFFF);
        send(3'd2);
        sync_in = 1'b1;
        step(4);
        check("R7 real sync ignored", irq, 1'b0);
        check("R7 pins ignored", rd_data, 16'hFFFF);
        sync_in = 1'b0;
        step(3);
        send(3'd7);
        step(3);
        check("R7 zeros irq", irq, 1'b1);
        check("R7 zeros word", rd_data, 16'h0000);
        send(3'd2);
        send(3'd4);
        step(3);
        check("R7 forcing ended", rd_data, 16'h0F0F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule